// File: doc/BRIEF.md
# Phase-Error PID Loop Controller

This block closes the loop of a digital phase-locked demodulator. Each cycle in which the phase estimator presents a valid signed error sample, the controller forms a proportional, an integral and a derivative term in fixed point. Each gain is a 16-bit constant with seven fractional bits. The controller adds the three terms and clamps the sum to the signed output width. The clamped sum is the correction and is also the demodulated output. The same correction, added to a fixed 26-bit centre-frequency word, forms the phase step for the local oscillator.

The controller keeps two pieces of state: the integrator and the last valid error sample. A small state machine records whether the last output was within range (ST_TRACK), clamped high (ST_SAT_HI) or clamped low (ST_SAT_LO). ST_IDLE is the state after reset, before any sample. On every valid sample the machine moves from any state to ST_TRACK, ST_SAT_HI or ST_SAT_LO, chosen by the unclamped sum of that sample. Without a sample it stays where it is. In a clamped state the integrator refuses any increment that would push further into the same limit.

Top module: `dpll_loop_filter`

## Requirements
- R1: After reset, corr_valid is 0, corr_out is 0 and nco_step is 2^19. The integrator and the stored previous error are both 0.
- R2: corr_valid is 1 in exactly the cycle after a cycle with err_valid high, and 0 otherwise. corr_out and nco_step change only then.
- R3: With e the sample and a >>> 7 the arithmetic right shift (rounding toward minus infinity), the proportional term is (2*e)>>>7, the integrator increment is e>>>7 and the derivative term is (2*(e - e_prev))>>>7.
- R4: The integrator adds its increment on every valid sample, and the correction equals proportional + integrator (after this sample's update) + derivative.
- R5: e_prev is the most recent sample taken with err_valid high. Values on err_in while err_valid is low have no effect on any later output.
- R6: The correction is clamped to the range -32768 to 32767 and never wraps.
- R7: The integrator is clamped to the same range. While the last output was clamped high, a positive increment is dropped. While it was clamped low, a negative increment is dropped.
- R8: nco_step equals 2^19 plus the sign-extended correction, modulo 2^26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_valid | input | 1 | err_in carries a new sample this cycle |
| err_in | input | 16 | Signed phase error from the estimator |
| corr_valid | output | 1 | One-cycle pulse marking a new correction |
| corr_out | output | 16 | Signed correction, the demodulated output |
| nco_step | output | 26 | Phase step for the local oscillator |

## Verification
The controller is driven in four ways:
- A table of mixed samples with idle gaps of junk data. This separates the proportional, integral and derivative contributions from one another. It also shows whether junk data leaks into the stored previous error.
- Hand-computed first samples after reset. These pin down the floor rounding on negative values and the reset of the state.
- A long positive ramp followed by a sign reversal. This pushes the output into the upper clamp while the integrator is still short of its own limit, so a missing freeze shows as a different recovered value.
- A sustained negative run. This exercises the lower clamp and the recovery from it.

// File: rtl/dpll_lf_pkg.sv
package dpll_lf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRACK,
        ST_SAT_HI,
        ST_SAT_LO
    } lf_state_e;

    // Clamp a signed value to the range of a w-bit two's complement number.
    function automatic logic signed [63:0] sat_to(input logic signed [63:0] v,
                                                  input int unsigned w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (v > hi)
            return hi;
        else if (v < lo)
            return lo;
        else
            return v;
    endfunction

endpackage

// File: rtl/dpll_lf_gain.sv
// Fixed-point constant gain: multiply, then drop the fractional bits by an
// arithmetic shift (floor rounding).
module dpll_lf_gain #(
    parameter int IN_W   = 17,
    parameter int GAIN_W = 16,
    parameter int FRAC   = 7,
    parameter int GAIN   = 1,
    parameter int OUT_W  = 35
) (
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);
    localparam logic signed [GAIN_W-1:0] G = GAIN_W'(GAIN);

    logic signed [OUT_W-1:0] x_ext;
    logic signed [OUT_W-1:0] g_ext;
    logic signed [OUT_W-1:0] prod;

    always_comb begin
        x_ext = OUT_W'(x);
        g_ext = OUT_W'(G);
        prod  = x_ext * g_ext;
        y     = prod >>> FRAC;
    end
endmodule

// File: rtl/dpll_lf_integrator.sv
// Saturating accumulator with directional freeze (anti-windup).
module dpll_lf_integrator
    import dpll_lf_pkg::*;
#(
    parameter int STEP_W = 35,
    parameter int ACC_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic                     hold_up,
    input  logic                     hold_dn,
    input  logic signed [STEP_W-1:0] step,
    output logic signed [ACC_W-1:0]  acc_q,
    output logic signed [ACC_W-1:0]  acc_d
);
    logic                     step_pos;
    logic                     step_neg;
    logic                     frozen;
    logic signed [STEP_W-1:0] sum;
    logic signed [63:0]       clipped;

    always_comb begin
        step_neg = step[STEP_W-1];
        step_pos = !step[STEP_W-1] && (step != '0);
        frozen   = (hold_up && step_pos) || (hold_dn && step_neg);
        sum      = STEP_W'(acc_q) + step;
        clipped  = sat_to(64'(sum), ACC_W);
        if (upd && !frozen)
            acc_d = clipped[ACC_W-1:0];
        else
            acc_d = acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end
endmodule

// File: rtl/dpll_lf_fsm.sv
// Tracks whether the last correction sat inside or at a limit of the range.
module dpll_lf_fsm
    import dpll_lf_pkg::*;
#(
    parameter int SUM_W = 35,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample,
    input  logic signed [SUM_W-1:0] raw,
    output lf_state_e               state_q,
    output logic                    hold_up,
    output logic                    hold_dn
);
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] LO = SUM_W'(-(64'sd1 <<< (OUT_W - 1)));

    lf_state_e cls;
    lf_state_e state_d;

    always_comb begin
        if (raw > HI)
            cls = ST_SAT_HI;
        else if (raw < LO)
            cls = ST_SAT_LO;
        else
            cls = ST_TRACK;

        unique case (state_q)
            ST_IDLE:   state_d = sample ? cls : ST_IDLE;
            ST_TRACK:  state_d = sample ? cls : ST_TRACK;
            ST_SAT_HI: state_d = sample ? cls : ST_SAT_HI;
            ST_SAT_LO: state_d = sample ? cls : ST_SAT_LO;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        hold_up = 1'b0;
        hold_dn = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_TRACK:  ;
            ST_SAT_HI: hold_up = 1'b1;
            ST_SAT_LO: hold_dn = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
    import dpll_lf_pkg::*;
#(
    parameter int ERR_W   = 16,
    parameter int OUT_W   = 16,
    parameter int GAIN_W  = 16,
    parameter int FRAC    = 7,
    parameter int KP      = 2,
    parameter int KI      = 1,
    parameter int KD      = 2,
    parameter int NCO_W   = 26,
    parameter int REF_BIT = 19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] err_in,
    output logic                    corr_valid,
    output logic signed [OUT_W-1:0] corr_out,
    output logic [NCO_W-1:0]        nco_step
);
    localparam int DIFF_W  = ERR_W + 1;
    localparam int WIDE_W  = DIFF_W + GAIN_W + 2;
    localparam int N_TERMS = 3;
    localparam int GAINS [N_TERMS] = '{KP, KI, KD};
    localparam logic [NCO_W-1:0] REF_WORD = {{(NCO_W-1){1'b0}}, 1'b1} << REF_BIT;

    logic signed [ERR_W-1:0]  prev_q;
    logic signed [DIFF_W-1:0] term_in  [N_TERMS];
    logic signed [WIDE_W-1:0] term_out [N_TERMS];
    logic signed [OUT_W-1:0]  integ_q;
    logic signed [OUT_W-1:0]  integ_d;
    logic signed [WIDE_W-1:0] raw;
    logic signed [63:0]       clamped;
    logic signed [OUT_W-1:0]  corr_d;
    logic                     hold_up;
    logic                     hold_dn;
    lf_state_e                state_q;

    // Term inputs: 0 proportional, 1 integral step, 2 derivative.
    always_comb begin
        term_in[0] = DIFF_W'(err_in);
        term_in[1] = DIFF_W'(err_in);
        term_in[2] = DIFF_W'(err_in) - DIFF_W'(prev_q);
    end

    for (genvar g = 0; g < N_TERMS; g++) begin : g_term
        dpll_lf_gain #(
            .IN_W  (DIFF_W),
            .GAIN_W(GAIN_W),
            .FRAC  (FRAC),
            .GAIN  (GAINS[g]),
            .OUT_W (WIDE_W)
        ) u_gain (
            .x(term_in[g]),
            .y(term_out[g])
        );
    end

    dpll_lf_integrator #(
        .STEP_W(WIDE_W),
        .ACC_W (OUT_W)
    ) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (err_valid),
        .hold_up(hold_up),
        .hold_dn(hold_dn),
        .step   (term_out[1]),
        .acc_q  (integ_q),
        .acc_d  (integ_d)
    );

    always_comb begin
        raw     = term_out[0] + WIDE_W'(integ_d) + term_out[2];
        clamped = sat_to(64'(raw), OUT_W);
        corr_d  = clamped[OUT_W-1:0];
    end

    dpll_lf_fsm #(
        .SUM_W(WIDE_W),
        .OUT_W(OUT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (err_valid),
        .raw    (raw),
        .state_q(state_q),
        .hold_up(hold_up),
        .hold_dn(hold_dn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= '0;
            corr_valid <= 1'b0;
            corr_out   <= '0;
            nco_step   <= REF_WORD;
        end else begin
            corr_valid <= err_valid;
            if (err_valid) begin
                prev_q   <= err_in;
                corr_out <= corr_d;
                nco_step <= REF_WORD + NCO_W'(corr_d);
            end
        end
    end
endmodule

// File: rtl/dpll_lf_checker.sv
module dpll_lf_checker
    import dpll_lf_pkg::*;
#(
    parameter int ERR_W   = 16,
    parameter int OUT_W   = 16,
    parameter int NCO_W   = 26,
    parameter int REF_BIT = 19,
    parameter int FRAC    = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    err_valid,
    input logic signed [ERR_W-1:0] err_in,
    input logic                    corr_valid,
    input logic signed [OUT_W-1:0] corr_out,
    input logic [NCO_W-1:0]        nco_step,
    input lf_state_e               state_q,
    input logic signed [OUT_W-1:0] integ_q
);
    localparam logic [NCO_W-1:0] REF_WORD = {{(NCO_W-1){1'b0}}, 1'b1} << REF_BIT;
    localparam logic signed [ERR_W-1:0] STEP_ONE = ERR_W'(1 << FRAC);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> corr_valid);                                  // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> !corr_valid);                                // R2
    AST_HOLD_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> ($stable(corr_out) && $stable(nco_step)));   // R5
    AST_NCO_MATCHES_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> (nco_step == REF_WORD + NCO_W'(corr_out)));  // R8
    AST_FREEZE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAT_HI && err_valid && err_in >= STEP_ONE)
        |=> $stable(integ_q));                                      // R7
    AST_FREEZE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAT_LO && err_valid && err_in[ERR_W-1])
        |=> $stable(integ_q));                                      // R7
endmodule

bind dpll_loop_filter dpll_lf_checker #(
    .ERR_W  (ERR_W),
    .OUT_W  (OUT_W),
    .NCO_W  (NCO_W),
    .REF_BIT(REF_BIT),
    .FRAC   (FRAC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_in    (err_in),
    .corr_valid(corr_valid),
    .corr_out  (corr_out),
    .nco_step  (nco_step),
    .state_q   (state_q),
    .integ_q   (integ_q)
);

// File: tb/dpll_loop_filter_tb.sv
module dpll_loop_filter_tb;
    localparam int REF  = 1 << 19;
    localparam int MASK = (1 << 26) - 1;

    typedef struct packed {
        logic signed [31:0] err;
        logic [31:0]        gap;
        logic signed [31:0] junk;
    } vec_t;

    // err: sample, gap: idle cycles after it, junk: err_in value during the gap
    localparam vec_t VECS [0:11] = '{
        '{32'sd100,    32'd0, 32'sd0},
        '{32'sd127,    32'd2, 32'sd30000},
        '{32'sd128,    32'd0, 32'sd0},
        '{-32'sd1,     32'd1, -32'sd20000},
        '{-32'sd128,   32'd0, 32'sd0},
        '{-32'sd129,   32'd3, 32'sd12345},
        '{32'sd5000,   32'd0, 32'sd0},
        '{-32'sd5000,  32'd1, 32'sd7},
        '{32'sd32767,  32'd0, 32'sd0},
        '{-32'sd32768, 32'd2, 32'sd32767},
        '{32'sd300,    32'd0, 32'sd0},
        '{32'sd0,      32'd0, 32'sd0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               err_valid = 1'b0;
    logic signed [15:0] err_in = '0;
    logic               corr_valid;
    logic signed [15:0] corr_out;
    logic [25:0]        nco_step;

    int  n_chk = 0;
    int  n_bad = 0;
    int  m_int = 0;
    int  m_prev = 0;
    int  m_sat = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    dpll_loop_filter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (err_valid),
        .err_in    (err_in),
        .corr_valid(corr_valid),
        .corr_out  (corr_out),
        .nco_step  (nco_step)
    );

    function automatic int clip16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Reference model of the control law from the requirements.
    task automatic model(input int e, output int u);
        int p, ii, d, s;
        bit frz;
        p   = (2 * e) >>> 7;
        ii  = e >>> 7;
        d   = (2 * (e - m_prev)) >>> 7;
        frz = (m_sat == 1 && ii > 0) || (m_sat == -1 && ii < 0);
        if (!frz) m_int = clip16(m_int + ii);
        s     = p + m_int + d;
        m_sat = (s > 32767) ? 1 : ((s < -32768) ? -1 : 0);
        u     = clip16(s);
        m_prev = e;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        err_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_int = 0; m_prev = 0; m_sat = 0;
        check("R1", "corr_valid", int'(corr_valid), 0);
        check("R1", "corr_out", int'(corr_out), 0);
        check("R1", "nco_step", int'(nco_step), REF);
    endtask

    task automatic apply(input int e, input string req);
        int u;
        @(negedge clk);
        err_in = 16'(e);
        err_valid = 1'b1;
        @(negedge clk);
        err_valid = 1'b0;
        model(e, u);
        check(req, "corr_valid", int'(corr_valid), 1);
        check(req, "corr_out", int'(corr_out), u);
        check("R8", "nco_step", int'(nco_step), (REF + u) & MASK);
    endtask

    task automatic idle(input int cycles, input int junk);
        int held;
        held = int'(corr_out);
        for (int k = 0; k < cycles; k++) begin
            err_in = 16'(junk);
            @(negedge clk);
            check("R2", "corr_valid idle", int'(corr_valid), 0);
            check("R5", "corr_out idle", int'(corr_out), held);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset();

        // R3: first sample after reset, 1000 -> 15 + 7 + 15
        apply(1000, "R3");
        check("R3", "corr_out literal", int'(corr_out), 37);

        // table walk
        for (int i = 0; i < 12; i++) begin
            apply(int'(VECS[i].err), "R4");
            idle(int'(VECS[i].gap), int'(VECS[i].junk));
        end

        // R3: negative rounding floors, -1000 -> -16 - 8 - 16
        do_reset();
        apply(-1000, "R3");
        check("R3", "corr_out literal", int'(corr_out), -40);

        // R5: junk during idle must not become the previous sample
        do_reset();
        apply(0, "R5");
        idle(3, 20000);
        apply(0, "R5");
        check("R5", "corr_out literal", int'(corr_out), 0);

        // R6/R7: upper clamp with integrator below its limit, then freeze
        do_reset();
        for (int k = 0; k < 124; k++) apply(32767, "R4");
        apply(-32768, "R4");
        apply(32767, "R6");
        check("R6", "corr_out clamp high", int'(corr_out), 32767);
        apply(32767, "R7");
        check("R7", "corr_out after freeze", int'(corr_out), 32130);
        for (int k = 0; k < 10; k++) apply(32767, "R7");

        // R6/R7: lower clamp and recovery
        do_reset();
        for (int k = 0; k < 140; k++) apply(-32768, "R6");
        check("R6", "corr_out clamp low", int'(corr_out), -32768);
        apply(0, "R7");
        apply(-200, "R7");
        apply(500, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule